// File: doc/BRIEF.md
# Scheduled Battery-Low Check Sequencer

This block decides when a backup battery gets measured and keeps the resulting battery-low indication. A measurement is requested each time the main supply becomes valid. While the supply stays valid, another measurement is requested after a fixed long interval, counted in slow clock-enable ticks. No measurement is ever requested while the system runs from the battery. The indication is updated only when a measurement completes. Between measurements it keeps its value.

Each measurement runs as a short handshake with an external comparator. The block raises a request and keeps it high for a settling period. It then takes the first comparator result that is marked valid. If the supply drops during a measurement, the measurement is abandoned. In that case the indication keeps its previous value, and a fresh measurement is owed at the next power-up. The analog comparison, the threshold voltage and the open-drain output pad are outside this block.

Top module: `batt_chk_seq`

## Requirements
- R1: During synchronous reset (rst_n low) `batt_low_n` is 1 and `meas_req` is 0. A measurement is pending for the first cycle in which `supply_ok` is high.
- R2: In the first cycle after reset in which `supply_ok` is high, a measurement starts. The same applies in the first such cycle after `supply_ok` was low. `meas_req` is 1 from the next clock edge.
- R3: `meas_req` stays high for SETTLE_CYCLES cycles before the comparator is sampled. `cmp_valid` during that window has no effect on `batt_low_n`. With no supply loss and `cmp_valid` already high, `meas_req` is high for exactly SETTLE_CYCLES+1 cycles.
- R4: After the settling window, the first cycle with `cmp_valid` high completes the measurement. At the next edge `batt_low_n` takes the value of NOT `cmp_low` (`cmp_low`=1 means the battery is below threshold) and `meas_req` returns to 0.
- R5: Outside a measurement's completing cycle, `batt_low_n` does not change, whatever `cmp_low`, `cmp_valid` or `tick` do.
- R6: Every measurement start triggered by a power-up restarts the interval count. Once the count reaches INTERVAL_TICKS ticks taken while `supply_ok` is high, a scheduled measurement starts at the edge that takes the last tick.
- R7: While `supply_ok` is low, `meas_req` is 0 and ticks are not counted.
- R8: If `supply_ok` goes low during a measurement, `meas_req` is 0 from the next edge and `batt_low_n` keeps its value.
- R9: If the interval expires while a measurement is in progress, the scheduled measurement is remembered. It starts one cycle after the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| supply_ok | input | 1 | Main supply valid |
| tick | input | 1 | Slow clock enable for interval timing |
| cmp_valid | input | 1 | Comparator result valid |
| cmp_low | input | 1 | Comparator result: 1 = battery below threshold |
| meas_req | output | 1 | Measurement request to the comparator |
| batt_low_n | output | 1 | Battery-low indication, active low |

## Verification
The embedded assertions check on every cycle that:
- no request appears or remains while the supply is invalid;
- a rising request always follows a valid-supply cycle;
- the indication never changes without a preceding full settling window;
- an invalid-supply cycle leaves the indication untouched;
- the interval count stays frozen without supply.

The bench scenarios establish the rest:
- the exact settling length;
- the moment a scheduled measurement fires relative to the last tick;
- that an expiry falling inside a long measurement is served afterwards;
- that abort-then-restore produces a fresh measurement.

A behavioural model checks every clock for all of these.

// File: rtl/batt_chk_pkg.sv
// Package: shared types for the battery-check sequencer.
package batt_chk_pkg;
    // Measurement sequencer states.
    typedef enum logic [1:0] {
        CHK_IDLE   = 2'd0,
        CHK_SETTLE = 2'd1,
        CHK_WAIT   = 2'd2
    } chk_state_t;
endpackage

// File: rtl/batt_chk_interval.sv
// Module: batt_chk_interval
// Counts enable ticks while the supply is valid and flags the tick that
// completes a full interval. The count restarts on request and is frozen
// while the supply is invalid.
// Assumes INTERVAL_TICKS >= 2.
module batt_chk_interval #(
    parameter int unsigned INTERVAL_TICKS = 86400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick,
    input  logic restart,
    output logic due
);
    localparam int unsigned CW = $clog2(INTERVAL_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Expiry: the tick that takes the count past its last value.
    always_comb begin
        due = supply_ok && tick && (cnt_q == LAST);
    end

    // Interval count: restart, or advance on a powered tick with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (supply_ok && tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R7: no counting while running on the battery.
    p_frozen_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable(cnt_q));
endmodule

// File: rtl/batt_chk_fsm.sv
// Module: batt_chk_fsm
// Runs one measurement handshake at a time. A measurement starts on
// power-up, on interval expiry, or on a remembered expiry. The request is
// held for SETTLE_CYCLES cycles, then the first valid comparator result is
// latched into the battery-low flag. A supply loss aborts the measurement
// and leaves the flag unchanged.
// Assumes SETTLE_CYCLES >= 1.
module batt_chk_fsm
    import batt_chk_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic due,
    input  logic cmp_valid,
    input  logic cmp_low,
    output logic restart,
    output logic meas_req,
    output logic batt_low_n
);
    localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

    chk_state_t    st_q;
    logic [SW-1:0] sc_q;
    logic          req_q;
    logic          pu_pend_q;
    logic          sch_pend_q;
    logic          low_q;
    logic          start;
    logic          done;

    // Start and completion conditions.
    always_comb begin
        start   = supply_ok && (st_q == CHK_IDLE) && (pu_pend_q || sch_pend_q || due);
        restart = supply_ok && (st_q == CHK_IDLE) && pu_pend_q;
        done    = supply_ok && (st_q == CHK_WAIT) && cmp_valid;
    end

    // Sequencer: idle, settle window, wait for a valid result; abort on supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CHK_IDLE;
            sc_q  <= '0;
            req_q <= 1'b0;
        end else if (!supply_ok) begin
            st_q  <= CHK_IDLE;
            req_q <= 1'b0;
        end else begin
            case (st_q)
                CHK_IDLE: begin
                    if (start) begin
                        st_q  <= CHK_SETTLE;
                        sc_q  <= '0;
                        req_q <= 1'b1;
                    end
                end
                CHK_SETTLE: begin
                    if (sc_q == SETTLE_LAST) begin
                        st_q <= CHK_WAIT;
                    end else begin
                        sc_q <= sc_q + 1'b1;
                    end
                end
                CHK_WAIT: begin
                    if (cmp_valid) begin
                        st_q  <= CHK_IDLE;
                        req_q <= 1'b0;
                    end
                end
                default: begin
                    st_q  <= CHK_IDLE;
                    req_q <= 1'b0;
                end
            endcase
        end
    end

    // Power-up pending: set by reset and by every invalid-supply cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_pend_q <= 1'b1;
        end else if (!supply_ok) begin
            pu_pend_q <= 1'b1;
        end else if (start) begin
            pu_pend_q <= 1'b0;
        end
    end

    // Scheduled pending: remembers an expiry that arrives during a measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_pend_q <= 1'b0;
        end else if (start) begin
            sch_pend_q <= 1'b0;
        end else if (supply_ok && due) begin
            sch_pend_q <= 1'b1;
        end
    end

    // Battery-low flag: updated only when a measurement completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= 1'b0;
        end else if (done) begin
            low_q <= cmp_low;
        end
    end

    assign meas_req   = req_q;
    assign batt_low_n = ~low_q;

    // R5: the flag holds unless the sequencer is waiting and a result is valid.
    p_hold_between_checks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q == CHK_WAIT) && cmp_valid) |=> $stable(low_q));
    // R9: a remembered expiry is never left behind while idle and powered.
    p_sched_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_pend_q && supply_ok && (st_q == CHK_IDLE)) |=> (meas_req || !$past(supply_ok)));
endmodule

// File: rtl/batt_chk_seq.sv
// Module: batt_chk_seq (top)
// Battery-check scheduler. It combines the interval counter with the
// measurement sequencer. Ports follow the request/valid handshake to
// an external comparator.
// Assumes tick is a single-cycle enable and all inputs are synchronous to clk.
module batt_chk_seq #(
    parameter int unsigned INTERVAL_TICKS = 86400,
    parameter int unsigned SETTLE_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick,
    input  logic cmp_valid,
    input  logic cmp_low,
    output logic meas_req,
    output logic batt_low_n
);
    localparam int unsigned AW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [AW-1:0] AGE_MAX = AW'(SETTLE_CYCLES);

    logic due;
    logic restart;

    batt_chk_interval #(
        .INTERVAL_TICKS(INTERVAL_TICKS)
    ) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .tick     (tick),
        .restart  (restart),
        .due      (due)
    );

    batt_chk_fsm #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .due       (due),
        .cmp_valid (cmp_valid),
        .cmp_low   (cmp_low),
        .restart   (restart),
        .meas_req  (meas_req),
        .batt_low_n(batt_low_n)
    );

    // Checker state: how long the request has been high, saturating.
    logic [AW-1:0] req_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_age_q <= '0;
        end else if (!meas_req) begin
            req_age_q <= '0;
        end else if (req_age_q != AGE_MAX) begin
            req_age_q <= req_age_q + 1'b1;
        end
    end

    // R7: no request is present after an invalid-supply cycle.
    p_no_req_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !meas_req);
    // R2: a request only begins after a valid-supply cycle.
    p_req_needs_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_req) |-> $past(supply_ok));
    // R3: the flag only moves after a full settling window.
    p_settle_before_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(batt_low_n) |-> ($past(req_age_q) >= AGE_MAX));
    // R8: a supply loss never alters the flag.
    p_abort_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable(batt_low_n));
endmodule

// File: tb/batt_chk_seq_test.sv
module batt_chk_seq_test;
    localparam int IV  = 6;
    localparam int SET = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic tick = 1'b0;
    logic cmp_valid = 1'b0;
    logic cmp_low = 1'b0;
    logic meas_req;
    logic batt_low_n;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    batt_chk_seq #(.INTERVAL_TICKS(IV), .SETTLE_CYCLES(SET)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
        .cmp_valid(cmp_valid), .cmp_low(cmp_low),
        .meas_req(meas_req), .batt_low_n(batt_low_n)
    );

    // Behavioural reference: phase 0 idle, 1 settling, 2 waiting for result.
    int  m_phase = 0, m_settle = 0, m_ticks = 0;
    bit  m_pu = 1'b1, m_sched = 1'b0, m_low = 1'b0, m_req = 1'b0;
    bit  started = 1'b0;

    always @(posedge clk) begin
        bit expire;
        bit go;
        started = 1'b1;
        if (!rst_n) begin
            m_phase = 0; m_settle = 0; m_ticks = 0;
            m_pu = 1'b1; m_sched = 1'b0; m_low = 1'b0; m_req = 1'b0;
        end else if (!supply_ok) begin
            m_phase = 0; m_req = 1'b0; m_pu = 1'b1;
        end else begin
            expire = tick && (m_ticks == IV - 1);
            go = (m_phase == 0) && (m_pu || m_sched || expire);
            if (go && m_pu) m_ticks = 0;
            else if (tick) m_ticks = expire ? 0 : m_ticks + 1;
            if (go) begin
                m_phase = 1; m_settle = 0; m_req = 1'b1;
                m_pu = 1'b0; m_sched = 1'b0;
            end else begin
                if (expire) m_sched = 1'b1;
                if (m_phase == 1) begin
                    m_settle++;
                    if (m_settle == SET) m_phase = 2;
                end else if (m_phase == 2 && cmp_valid) begin
                    m_low = cmp_low; m_phase = 0; m_req = 1'b0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R4 flag, R2/R3 request).
    always @(negedge clk) begin
        if (started && rst_n && !done_flag) begin
            chk(meas_req == m_req, "R3 model meas_req", meas_req, m_req);
            chk(batt_low_n == !m_low, "R4 model batt_low_n", batt_low_n, !m_low);
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            done_flag = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            summary();
        end
    end

    // Wait at negedges until meas_req equals val; returns negedges waited.
    task automatic wait_req(input bit val, input int maxn, output int n);
        n = 0;
        while (meas_req !== val && n < maxn) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int hi;
        repeat (3) @(negedge clk);
        chk(batt_low_n == 1'b1, "R1 reset batt_low_n", batt_low_n, 1);
        chk(meas_req == 1'b0, "R1 reset meas_req", meas_req, 0);
        rst_n = 1'b1;
        tick = 1'b1;
        repeat (4) @(negedge clk);
        chk(meas_req == 1'b0, "R7 no request unpowered", meas_req, 0);

        // First power-up measurement, comparator reports low during settling.
        tick = 1'b0;
        supply_ok = 1'b1;
        @(negedge clk);
        chk(meas_req == 1'b1, "R2 power-up request", meas_req, 1);
        cmp_valid = 1'b1; cmp_low = 1'b1;
        hi = 1;
        repeat (2) begin
            @(negedge clk);
            if (meas_req) hi++;
            chk(batt_low_n == 1'b1, "R3 ignored during settle", batt_low_n, 1);
        end
        while (meas_req && hi < 20) begin
            @(negedge clk);
            if (meas_req) hi++;
        end
        chk(hi == SET + 1, "R3 request length", hi, SET + 1);
        chk(batt_low_n == 1'b0, "R4 low result latched", batt_low_n, 0);
        cmp_valid = 1'b0;

        // Hold between measurements.
        repeat (10) begin
            @(negedge clk);
            cmp_low = ~cmp_low;
        end
        chk(batt_low_n == 1'b0, "R5 flag held", batt_low_n, 0);

        // Scheduled measurement after IV powered ticks.
        tick = 1'b1;
        wait_req(1'b1, 40, n);
        tick = 1'b0;
        chk(n == IV, "R6 interval length", n, IV);
        cmp_low = 1'b0; cmp_valid = 1'b1;
        wait_req(1'b0, 20, n);
        chk(batt_low_n == 1'b1, "R6 scheduled result", batt_low_n, 1);
        cmp_valid = 1'b0;

        // Abort during a measurement.
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        wait_req(1'b1, 10, n);
        cmp_low = 1'b1;
        repeat (2) @(negedge clk);
        supply_ok = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        chk(meas_req == 1'b0, "R8 abort drops request", meas_req, 0);
        chk(batt_low_n == 1'b1, "R8 flag unchanged", batt_low_n, 1);
        repeat (5) @(negedge clk);
        chk(meas_req == 1'b0, "R7 ticks while unpowered", meas_req, 0);
        tick = 1'b0;
        supply_ok = 1'b1;
        @(negedge clk);
        chk(meas_req == 1'b1, "R2 restart after abort", meas_req, 1);
        cmp_low = 1'b0; cmp_valid = 1'b1;
        wait_req(1'b0, 20, n);
        cmp_valid = 1'b0;
        chk(batt_low_n == 1'b1, "R5 good result keeps high", batt_low_n, 1);

        // Expiry inside a long measurement.
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        tick = 1'b1;
        repeat (10) @(negedge clk);
        tick = 1'b0;
        chk(meas_req == 1'b1, "R9 still measuring", meas_req, 1);
        cmp_low = 1'b1; cmp_valid = 1'b1;
        wait_req(1'b0, 10, n);
        cmp_valid = 1'b0;
        chk(batt_low_n == 1'b0, "R4 long measurement result", batt_low_n, 0);
        @(negedge clk);
        chk(meas_req == 1'b1, "R9 remembered expiry served", meas_req, 1);
        cmp_low = 1'b0; cmp_valid = 1'b1;
        wait_req(1'b0, 20, n);
        cmp_valid = 1'b0;
        chk(batt_low_n == 1'b1, "R9 second result", batt_low_n, 1);
        repeat (3) @(negedge clk);

        done_flag = 1'b1;
        summary();
    end
endmodule